// File: doc/BRIEF.md
# Cache-Line Transmit Descriptor Splitter

The block takes 64-byte transmit descriptors, each written by the host as one whole cache line, and turns them into a byte stream for the MAC side. One flag bit in the descriptor selects the mode. An inline descriptor carries a complete small frame of up to 60 bytes. This is a minimum-size Ethernet frame without its 4-byte FCS. A split descriptor carries the first 48 bytes of a larger frame (the headers), plus a buffer address and a total frame length. For a split descriptor the block sends the 48 header bytes, issues one payload fetch on a DMA request port, and appends the returned payload bytes behind the header. Header splitting therefore never needs a second descriptor.

Inline and split descriptors wait in separate queues. At each frame boundary a waiting inline frame wins over a waiting split frame, so a small frame may leave ahead of an earlier split frame. When a split frame's last byte leaves, the block raises a one-cycle completion carrying the descriptor's tag, so the host can reclaim its buffer. A descriptor with an out-of-range length is dropped and counted. The FCS is never expected in the descriptor and never appended here.

Every data interface is valid/ready, and a transfer happens on a clock edge where both are high. A sender keeps valid and its data stable until the transfer happens. The block holds `tx_valid` and `tx_data` stable while `tx_ready` is low. It holds `fetch_valid` and its fields stable until `fetch_ready`. It raises `fill_ready` only while it is forwarding payload, and then only when `tx_ready` is high. `desc_ready` depends on the mode and length of the offered descriptor: a descriptor that will be dropped is always accepted, and a good one is accepted only when its queue has room.

Top module: `txdesc_splitter`

## Requirements
- R1: A descriptor transfers on `desc_valid && desc_ready`. Byte i of the descriptor is `desc_data[8*i+7:8*i]`, and bit 0 of byte 63 set to 1 selects inline mode. A good descriptor is refused (`desc_ready` low) while its queue, `QDEPTH` entries deep, is full.
- R2: In inline mode, byte 60 gives the frame length L, valid from 1 to 60. Exactly L bytes leave on `tx_data`: descriptor bytes 0 to L-1 in order, with `tx_last` on the final byte and no FCS added.
- R3: In split mode, bytes 52-53 give the total frame length N, least significant byte first, valid from 48 to `MAX_FRAME`. Exactly N bytes leave: descriptor bytes 0 to 47, then N-48 bytes taken from `fill_data` in order, with `tx_last` on the final byte.
- R4: For each split frame with N > 48, exactly one fetch is issued. Its `fetch_addr` comes from bytes 48-51, least significant byte first, and its `fetch_len` equals N-48. When N is 48, no fetch is issued. A pending fetch stays stable until accepted.
- R5: One cycle after the last byte of a split frame transfers, `done_valid` is high for one cycle and `done_tag` equals descriptor byte 54. Inline frames raise no completion.
- R6: A descriptor with an out-of-range length is accepted and produces no output. It increments `drop_count`, which saturates at its all-ones value.
- R7: At a frame boundary a queued inline frame is started before any queued split frame, even one that arrived earlier. A frame in progress is never interrupted.
- R8: While `tx_ready` is low, `tx_valid` and `tx_data` hold. `fill_ready` is high only during payload forwarding, together with `tx_ready`.
- R9: After reset `tx_valid`, `fetch_valid` and `done_valid` are low, `drop_count` is zero and `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_data | input | 512 | Whole 64-byte descriptor |
| desc_ready | output | 1 | Descriptor accepted this cycle |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output frame byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | MAC side accepts the byte |
| fetch_valid | output | 1 | Payload fetch request |
| fetch_addr | output | 32 | Payload buffer address |
| fetch_len | output | 16 | Payload byte count |
| fetch_ready | input | 1 | Fetch request accepted |
| fill_valid | input | 1 | Returned payload byte valid |
| fill_data | input | 8 | Returned payload byte |
| fill_ready | output | 1 | Payload byte consumed |
| done_valid | output | 1 | Split frame finished (one cycle) |
| done_tag | output | 8 | Tag of the finished split frame |
| drop_count | output | ERR_W | Saturating count of dropped descriptors |

## Verification
A wrong byte index or a wrong mode decode shows up within the first frame as a mismatched or shifted byte. A bad length latch shows up as a frame that is too long or too short at `tx_last`, about N cycles after the descriptor is accepted. A wrong arbitration choice is visible as a reordered frame sequence as soon as two queues hold entries at once. A lost fetch or completion stalls the stream, or leaves `done_valid` silent one cycle after the last byte. Queue-count errors appear as a wrong `desc_ready` when the queue is exactly full.

// File: rtl/tds_pkg.sv
package tds_pkg;
  localparam int DESC_BYTES = 64;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int HDR_BYTES  = 48;
  localparam int INLINE_MAX = 60;
  // field byte offsets inside a descriptor
  localparam int OFS_ILEN = 60;
  localparam int OFS_ADDR = 48;
  localparam int OFS_LEN  = 52;
  localparam int OFS_TAG  = 54;
  localparam int OFS_FLAG = 63;

  typedef logic [DESC_W-1:0] desc_t;
  typedef enum logic [1:0] {EM_IDLE, EM_INL, EM_HDR, EM_PAY} em_state_t;

  function automatic logic [7:0] desc_byte(desc_t d, int unsigned i);
    return d[8*i +: 8];
  endfunction
  function automatic logic is_inline(desc_t d);
    return d[8*OFS_FLAG];
  endfunction
  function automatic logic [7:0] inline_len(desc_t d);
    return d[8*OFS_ILEN +: 8];
  endfunction
  function automatic logic [31:0] buf_addr(desc_t d);
    return d[8*OFS_ADDR +: 32];
  endfunction
  function automatic logic [15:0] frame_len(desc_t d);
    return d[8*OFS_LEN +: 16];
  endfunction
  function automatic logic [7:0] desc_tag(desc_t d);
    return d[8*OFS_TAG +: 8];
  endfunction
endpackage

// File: rtl/tds_fifo.sv
module tds_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  assign full  = (cnt == CNT_FULL);
  assign empty = (cnt == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full) else $error("queue overflow"); // R1
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty) else $error("queue underflow"); // R2
endmodule

// File: rtl/tds_classify.sv
module tds_classify #(
  parameter int MAX_FRAME = 1514,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode_inl,
  input  logic [7:0]       in_ilen,
  input  logic [15:0]      in_flen,
  output logic             in_ready,
  input  logic             inl_full,
  input  logic             dma_full,
  output logic             inl_push,
  output logic             dma_push,
  output logic [ERR_W-1:0] err_count
);
  import tds_pkg::*;
  localparam logic [15:0] MAXF  = 16'(MAX_FRAME);
  localparam logic [15:0] MINF  = 16'(HDR_BYTES);
  localparam logic [7:0]  IMAX  = 8'(INLINE_MAX);

  logic ok_inl, ok_dma, bad, drop;

  always_comb begin
    ok_inl   = (in_ilen != 8'd0) && (in_ilen <= IMAX);
    ok_dma   = (in_flen >= MINF) && (in_flen <= MAXF);
    bad      = in_mode_inl ? !ok_inl : !ok_dma;
    in_ready = bad || (in_mode_inl ? !inl_full : !dma_full);
    inl_push = in_valid && in_mode_inl  && !bad && !inl_full;
    dma_push = in_valid && !in_mode_inl && !bad && !dma_full;
    drop     = in_valid && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_count <= '0;
    else if (drop && (err_count != '1)) err_count <= err_count + 1'b1;
  end

  AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> err_count >= $past(err_count)) else $error("drop count fell"); // R6
endmodule

// File: rtl/tds_emit.sv
module tds_emit (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tds_pkg::desc_t       inl_head,
  input  logic                 inl_empty,
  output logic                 inl_pop,
  input  tds_pkg::desc_t       dma_head,
  input  logic                 dma_empty,
  output logic                 dma_pop,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  input  logic                 out_ready,
  output logic                 req_valid,
  output logic [31:0]          req_addr,
  output logic [15:0]          req_len,
  input  logic                 req_ready,
  input  logic                 rsp_valid,
  input  logic [7:0]           rsp_data,
  output logic                 rsp_ready,
  output logic                 cpl_valid,
  output logic [7:0]           cpl_tag
);
  import tds_pkg::*;
  localparam logic [5:0] HDR_LAST = 6'(HDR_BYTES - 1);

  em_state_t   st;
  logic [5:0]  idx;
  logic [15:0] pay_left;
  logic        req_pend;
  logic [7:0]  ilen_m1;
  logic [15:0] pay_len;
  logic        pay_zero;
  logic        fire;

  always_comb begin
    ilen_m1  = inline_len(inl_head) - 8'd1;
    pay_len  = frame_len(dma_head) - 16'(HDR_BYTES);
    pay_zero = (pay_len == 16'd0);
    req_valid = req_pend;
    req_addr  = buf_addr(dma_head);
    req_len   = pay_len;
    out_valid = 1'b0;
    out_data  = 8'd0;
    out_last  = 1'b0;
    rsp_ready = 1'b0;
    unique case (st)
      EM_INL: begin
        out_valid = 1'b1;
        out_data  = desc_byte(inl_head, 32'(idx));
        out_last  = ({2'b00, idx} == ilen_m1);
      end
      EM_HDR: begin
        out_valid = 1'b1;
        out_data  = desc_byte(dma_head, 32'(idx));
        out_last  = (idx == HDR_LAST) && pay_zero;
      end
      EM_PAY: begin
        out_valid = rsp_valid;
        out_data  = rsp_data;
        out_last  = rsp_valid && (pay_left == 16'd1);
        rsp_ready = out_ready;
      end
      default: ;
    endcase
    fire    = out_valid && out_ready;
    inl_pop = (st == EM_INL) && fire && out_last;
    dma_pop = ((st == EM_HDR) || (st == EM_PAY)) && fire && out_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= EM_IDLE;
      idx       <= '0;
      pay_left  <= '0;
      req_pend  <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
    end else begin
      cpl_valid <= dma_pop;
      if (dma_pop) cpl_tag <= desc_tag(dma_head);
      if (req_valid && req_ready) req_pend <= 1'b0;
      unique case (st)
        EM_IDLE: begin
          idx <= '0;
          if (!inl_empty) begin
            st <= EM_INL;
          end else if (!dma_empty) begin
            st       <= EM_HDR;
            req_pend <= !pay_zero;
          end
        end
        EM_INL: if (fire) begin
          if (out_last) st <= EM_IDLE;
          else          idx <= idx + 6'd1;
        end
        EM_HDR: if (fire) begin
          if (idx == HDR_LAST) begin
            if (pay_zero) st <= EM_IDLE;
            else begin
              st       <= EM_PAY;
              pay_left <= pay_len;
            end
          end else begin
            idx <= idx + 6'd1;
          end
        end
        EM_PAY: if (fire) begin
          pay_left <= pay_left - 16'd1;
          if (out_last) st <= EM_IDLE;
        end
        default: st <= EM_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("output not held"); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))) else $error("fetch not held"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpl_valid |=> !cpl_valid) else $error("completion longer than a cycle"); // R5
  AST_INLINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (st == EM_IDLE && !inl_empty) |=> (st == EM_INL)) else $error("inline frame not preferred"); // R7
endmodule

// File: rtl/txdesc_splitter.sv
module txdesc_splitter #(
  parameter int QDEPTH    = 4,
  parameter int MAX_FRAME = 1514,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  input  logic [511:0]     desc_data,
  output logic             desc_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  output logic             fetch_valid,
  output logic [31:0]      fetch_addr,
  output logic [15:0]      fetch_len,
  input  logic             fetch_ready,
  input  logic             fill_valid,
  input  logic [7:0]       fill_data,
  output logic             fill_ready,
  output logic             done_valid,
  output logic [7:0]       done_tag,
  output logic [ERR_W-1:0] drop_count
);
  import tds_pkg::*;

  logic  inl_push, dma_push, inl_pop, dma_pop;
  logic  inl_full, dma_full, inl_empty, dma_empty;
  desc_t inl_head, dma_head;

  tds_classify #(.MAX_FRAME(MAX_FRAME), .ERR_W(ERR_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .in_valid(desc_valid),
    .in_mode_inl(is_inline(desc_data)), .in_ilen(inline_len(desc_data)),
    .in_flen(frame_len(desc_data)), .in_ready(desc_ready),
    .inl_full(inl_full), .dma_full(dma_full),
    .inl_push(inl_push), .dma_push(dma_push), .err_count(drop_count)
  );

  tds_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_inl_q (
    .clk(clk), .rst_n(rst_n), .push(inl_push), .din(desc_data), .full(inl_full),
    .pop(inl_pop), .dout(inl_head), .empty(inl_empty)
  );

  tds_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_dma_q (
    .clk(clk), .rst_n(rst_n), .push(dma_push), .din(desc_data), .full(dma_full),
    .pop(dma_pop), .dout(dma_head), .empty(dma_empty)
  );

  tds_emit u_emit (
    .clk(clk), .rst_n(rst_n),
    .inl_head(inl_head), .inl_empty(inl_empty), .inl_pop(inl_pop),
    .dma_head(dma_head), .dma_empty(dma_empty), .dma_pop(dma_pop),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready),
    .req_valid(fetch_valid), .req_addr(fetch_addr), .req_len(fetch_len), .req_ready(fetch_ready),
    .rsp_valid(fill_valid), .rsp_data(fill_data), .rsp_ready(fill_ready),
    .cpl_valid(done_valid), .cpl_tag(done_tag)
  );
endmodule

// File: tb/sim_txdesc_splitter.sv
module sim_txdesc_splitter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0;
  logic [511:0] desc_data = '0;
  logic desc_ready, tx_valid, tx_last, fetch_valid, fill_ready, done_valid;
  logic [7:0] tx_data, done_tag;
  logic tx_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic [15:0] fetch_len;
  logic fill_valid = 1'b0;
  logic [7:0] fill_data = '0;
  logic [7:0] drop_count;

  int n_checks = 0, n_fail = 0, frames_done = 0, n_done = 0, n_fetch = 0;
  int last_fetch_len = 0;
  logic [7:0] last_tag = '0;
  logic [7:0] cap_q[$];
  logic [7:0] exp_q[$];
  logic bp_en = 1'b0, man_ready = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  bit finished = 0;

  always #10 clk = ~clk;

  txdesc_splitter u0 (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_data(desc_data),
    .desc_ready(desc_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_len(fetch_len), .fetch_ready(1'b1), .fill_valid(fill_valid),
    .fill_data(fill_data), .fill_ready(fill_ready), .done_valid(done_valid),
    .done_tag(done_tag), .drop_count(drop_count)
  );

  // mode, length, seed, tag
  localparam logic [32:0] VEC [11] = '{
    {1'b1, 16'd60,   8'h10, 8'h00},
    {1'b1, 16'd1,    8'h20, 8'h00},
    {1'b1, 16'd61,   8'h21, 8'h00},
    {1'b1, 16'd0,    8'h22, 8'h00},
    {1'b0, 16'd48,   8'h30, 8'hA1},
    {1'b0, 16'd49,   8'h40, 8'hA2},
    {1'b0, 16'd120,  8'h50, 8'hA3},
    {1'b0, 16'd47,   8'h51, 8'hA5},
    {1'b0, 16'd1515, 8'h52, 8'hA6},
    {1'b0, 16'd1514, 8'h60, 8'hA4},
    {1'b1, 16'd17,   8'h70, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [511:0] build_desc(logic m, logic [15:0] len, logic [7:0] seed, logic [7:0] tag);
    logic [511:0] d = '0;
    for (int i = 0; i < 60; i++) d[8*i +: 8] = seed + 8'(i);
    if (m) begin
      d[8*60 +: 8] = len[7:0];
      d[8*63] = 1'b1;
    end else begin
      d[8*48 +: 32] = 32'h8000_0000 | {24'd0, seed};
      d[8*52 +: 16] = len;
      d[8*54 +: 8]  = tag;
    end
    return d;
  endfunction

  task automatic add_exp(logic m, int len, logic [7:0] seed);
    for (int k = 0; k < len; k++)
      exp_q.push_back((m || k < 48) ? seed + 8'(k) : seed + 8'(k - 48));
  endtask

  task automatic send(input logic [511:0] d);
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_data = d;
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
    desc_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target, input string req);
    int t = 0;
    while (frames_done < target && t < 20000) begin @(negedge clk); t++; end
    chk(frames_done >= target, req, frames_done, target);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int bad = 0;
    chk(cap_q.size() == exp_q.size(), req, cap_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      if (cap_q[i] !== exp_q[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic clear_cap();
    cap_q.delete(); exp_q.delete();
  endtask

  // output collector and completion monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_q.push_back(tx_data);
      if (tx_last) frames_done++;
    end
    if (rst_n && done_valid) begin n_done++; last_tag = done_tag; end
  end

  // MAC-side ready pattern
  always begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = bp_en ? (lfsr[0] | lfsr[1]) : man_ready;
  end

  // DMA model: payload byte i = address low byte + i
  initial begin
    logic [31:0] a;
    int n;
    bit ok;
    forever begin
      @(negedge clk);
      if (rst_n && fetch_valid) begin
        a = fetch_addr; n = fetch_len; n_fetch++; last_fetch_len = n;
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
          fill_valid = 1'b1; fill_data = a[7:0] + 8'(i);
          do begin
            @(negedge clk); ok = fill_ready;
            @(posedge clk); #1;
          end while (!ok);
        end
        fill_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int fd0, fe0, dc0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!tx_valid, "R9", tx_valid, 0);
    chk(!fetch_valid, "R9", fetch_valid, 0);
    chk(!done_valid, "R9", done_valid, 0);
    chk(drop_count == 0, "R9", drop_count, 0);
    chk(desc_ready, "R9", desc_ready, 1);

    // table walk under random back-pressure (R8 exercised)
    bp_en = 1'b1;
    foreach (VEC[v]) begin
      logic m; logic [15:0] len; logic [7:0] seed, tag;
      bit good;
      {m, len, seed, tag} = VEC[v];
      good = m ? (len >= 1 && len <= 60) : (len >= 48 && len <= 1514);
      clear_cap();
      fd0 = n_done; fe0 = n_fetch; dc0 = drop_count;
      send(build_desc(m, len, seed, tag));
      if (good) begin
        add_exp(m, len, seed);
        wait_frames(frames_done + 1, m ? "R2" : "R3");
        cmp_stream(m ? "R2" : "R3");
        if (m) chk(n_done == fd0, "R5", n_done - fd0, 0);
        else begin
          chk(n_done == fd0 + 1, "R5", n_done - fd0, 1);
          chk(last_tag == tag, "R5", last_tag, tag);
          chk(n_fetch == fe0 + (len > 48 ? 1 : 0), "R4", n_fetch - fe0, len > 48);
          if (len > 48) chk(last_fetch_len == len - 48, "R4", last_fetch_len, len - 48);
        end
      end else begin
        repeat (10) @(negedge clk);
        chk(drop_count == dc0 + 1, "R6", drop_count, dc0 + 1);
        chk(cap_q.size() == 0, "R6", cap_q.size(), 0);
      end
    end

    // R7 overtake: inline C leaves before split B that arrived first
    bp_en = 1'b0; man_ready = 1'b0;
    repeat (2) @(posedge clk);
    clear_cap(); fd0 = frames_done;
    send(build_desc(1'b1, 16'd10, 8'h80, 8'h00));
    send(build_desc(1'b0, 16'd52, 8'h90, 8'hB1));
    send(build_desc(1'b1, 16'd5, 8'hA0, 8'h00));
    repeat (4) @(negedge clk);
    // R8 hold while stalled
    chk(tx_valid && tx_data == 8'h80, "R8", tx_data, 8'h80);
    chk(!fill_ready, "R8", fill_ready, 0);
    add_exp(1'b1, 10, 8'h80); add_exp(1'b1, 5, 8'hA0); add_exp(1'b0, 52, 8'h90);
    man_ready = 1'b1;
    wait_frames(fd0 + 3, "R7");
    cmp_stream("R7");
    chk(last_tag == 8'hB1, "R7", last_tag, 8'hB1);

    // R1 queue full refuses a good descriptor, still takes a bad one
    man_ready = 1'b0;
    repeat (2) @(posedge clk);
    clear_cap(); fd0 = frames_done;
    for (int i = 0; i < 4; i++) begin
      send(build_desc(1'b1, 16'd3, 8'(8'hC0 + 8'(i*16)), 8'h00));
      add_exp(1'b1, 3, 8'(8'hC0 + 8'(i*16)));
    end
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_data = build_desc(1'b1, 16'd3, 8'hF0, 8'h00);
    @(negedge clk);
    chk(!desc_ready, "R1", desc_ready, 0);
    @(posedge clk); #1;
    dc0 = drop_count;
    desc_data = build_desc(1'b1, 16'd0, 8'hF0, 8'h00);
    @(negedge clk);
    chk(desc_ready, "R1", desc_ready, 1);
    @(posedge clk); #1;
    desc_valid = 1'b0;
    @(negedge clk);
    chk(drop_count == dc0 + 1, "R6", drop_count, dc0 + 1);
    man_ready = 1'b1;
    wait_frames(fd0 + 4, "R1");
    cmp_stream("R1");

    // R6 saturation of drop counter
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_data = build_desc(1'b0, 16'd5, 8'h00, 8'h00);
    repeat (260) @(posedge clk);
    #1 desc_valid = 1'b0;
    @(negedge clk);
    chk(drop_count == 8'hFF, "R6", drop_count, 255);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule